// File: doc/BRIEF.md
# Early Receive Interrupt Generator

This block watches the bytes of an incoming Ethernet frame and raises an interrupt before the frame has finished arriving. Software programs a threshold in quadwords (8-byte units). The block reads the frame's Type/Length field and works out how many payload quadwords the frame will carry. It then counts payload quadwords down as they arrive. When the count still to come equals the threshold, the block sets an early-receive status bit. This lets a driver start work on the frame while its tail is still on the wire.

An end-of-frame status bit is set for every frame, whether early receive is enabled or not. Both status bits are sticky and are cleared by writing a one to them. An active-low level interrupt output stays asserted while any status bit is set. Software reaches the threshold and the status bits through a small register port with one address bit and registered read data.

Top module: `erx_early_irq`

## Requirements
- R1: The threshold register is 8 bits wide and sits at register address 0. It is readable and writable and resets to 00h. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R2: While the threshold is 00h, no early-receive event is produced.
- R3: The remaining count is the Type/Length value rounded up to whole quadwords, minus the number of complete quadwords of payload already received. With a non-zero threshold x, status bit 0 (early) is set on the clock edge after the byte that makes the remaining count equal x. If the count equals x as soon as the field is read, that byte is the second Type/Length byte.
- R4: A Type/Length value of 0600h or greater is an EtherType, and such a frame produces no early event.
- R5: A frame whose rounded-up length is smaller than x quadwords produces no early event.
- R6: Status bit 1 (end of frame) is set on the clock edge that accepts the byte marked end-of-frame. This happens for every frame, whatever the threshold.
- R7: At most one early event occurs per frame, even if the threshold is changed mid-frame. The next start-of-frame arms the block again.
- R8: The status register sits at address 1. Writing a one to a status bit clears it, and writing a zero leaves it unchanged. Reads return {6'b0, eof, early}.
- R9: `irq_n` is low from the edge that sets any status bit until the edge on which all status bits are clear.
- R10: The first byte of a frame carries start-of-frame. The Type/Length field is at bytes 12 and 13, high byte first, and payload begins at byte 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 threshold, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The bench uses the default parameters: the field at byte offset 12, 8-byte quadwords, an 8-bit threshold and an EtherType limit of 0600h. With an 8-bit threshold, a count of 192 can be programmed. That count meets the largest legal length, 1535, on its very first byte, so the length/EtherType boundary can be tested on both sides at 05FFh and 0600h. Odd lengths such as 37 exercise the round-up. Changing the threshold mid-frame, to a value the falling count is certain to reach, shows that the block fires only once per frame.

// File: rtl/erx_pkg.sv
`timescale 1ns/1ps
package erx_pkg;
  // status bit positions seen by software
  localparam int unsigned ST_EARLY = 0;
  localparam int unsigned ST_EOF   = 1;
  localparam int unsigned ST_W     = 2;

  typedef enum logic {
    ADDR_THR  = 1'b0,
    ADDR_STAT = 1'b1
  } erx_addr_e;
endpackage

// File: rtl/erx_frame_parser.sv
`timescale 1ns/1ps
module erx_frame_parser #(
  parameter int unsigned TL_OFFSET = 12,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  output logic             frame_start,
  output logic             frame_end,
  output logic             tl_load,
  output logic [LEN_W-1:0] tl_value,
  output logic             pay_byte
);
  localparam int unsigned PAY_POS = TL_OFFSET + 2;
  localparam int unsigned POS_W   = $clog2(PAY_POS + 1);

  logic [POS_W-1:0] pos_q;
  logic             in_frame_q;
  logic [7:0]       tl_hi_q;
  logic [POS_W-1:0] idx;
  logic             active;

  assign active      = rx_valid && (rx_sof || in_frame_q);
  assign idx         = rx_sof ? '0 : pos_q;
  assign frame_start = rx_valid && rx_sof;
  assign frame_end   = active && rx_eof;
  assign tl_load     = active && (idx == POS_W'(TL_OFFSET + 1));
  assign tl_value    = LEN_W'({tl_hi_q, rx_data});
  assign pay_byte    = active && !rx_sof && (pos_q == POS_W'(PAY_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
      tl_hi_q    <= '0;
    end else if (rx_valid) begin
      if (rx_sof) begin
        pos_q      <= POS_W'(1);
        in_frame_q <= !rx_eof;
      end else if (in_frame_q) begin
        if (pos_q != POS_W'(PAY_POS)) pos_q <= pos_q + 1'b1;
        if (rx_eof) in_frame_q <= 1'b0;
      end
      if (active && idx == POS_W'(TL_OFFSET)) tl_hi_q <= rx_data;
    end
  end

  // R10: the length field is only taken inside a frame that has started
  a_r10_field_inside_frame: assert property (@(posedge clk) disable iff (rst)
    tl_load |-> (in_frame_q && !rx_sof));
endmodule

// File: rtl/erx_qw_tracker.sv
`timescale 1ns/1ps
module erx_qw_tracker #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned QW_BYTES  = 8,
  parameter int unsigned THR_W     = 8,
  parameter logic [15:0] ETYPE_MIN = 16'h0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             tl_load,
  input  logic [LEN_W-1:0] tl_value,
  input  logic             pay_byte,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int unsigned QW_SHIFT = $clog2(QW_BYTES);
  localparam int unsigned REM_W    = LEN_W - QW_SHIFT + 1;

  logic [REM_W-1:0]    rem_q;
  logic [QW_SHIFT-1:0] qb_q;
  logic                tl_ok_q;
  logic                armed_q;
  logic [LEN_W:0]      len_sum;
  logic [REM_W-1:0]    rem_init;

  // round the length up to whole quadwords
  assign len_sum  = {1'b0, tl_value} + (LEN_W+1)'(QW_BYTES - 1);
  assign rem_init = len_sum[LEN_W:QW_SHIFT];

  assign hit = tl_ok_q && armed_q && (thr != '0) && (rem_q == REM_W'(thr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      qb_q    <= '0;
      tl_ok_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (frame_start) begin
      rem_q   <= '0;
      qb_q    <= '0;
      tl_ok_q <= 1'b0;
      armed_q <= 1'b1;
    end else if (frame_end) begin
      tl_ok_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (hit) armed_q <= 1'b0;
      if (tl_load) begin
        rem_q   <= rem_init;
        qb_q    <= '0;
        tl_ok_q <= (tl_value < LEN_W'(ETYPE_MIN));
      end else if (pay_byte) begin
        qb_q <= qb_q + 1'b1;
        if ((&qb_q) && rem_q != '0) rem_q <= rem_q - 1'b1;
      end
    end
  end

  // R2: a zero threshold never yields an early event
  a_r2_zero_thr_quiet: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |-> !hit);
  // R7: an early event is a single-cycle, once-per-frame pulse
  a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  // R4: an EtherType value blocks the early event
  a_r4_etype_blocks: assert property (@(posedge clk) disable iff (rst)
    (tl_load && !frame_start && !frame_end && tl_value >= LEN_W'(ETYPE_MIN)) |=> !hit);
endmodule

// File: rtl/erx_csr.sv
`timescale 1ns/1ps
module erx_csr
  import erx_pkg::*;
#(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [THR_W-1:0] reg_wdata,
  input  logic             set_early,
  input  logic             set_eof,
  output logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] reg_rdata,
  output logic             irq_n
);
  logic [THR_W-1:0] thr_q;
  logic [ST_W-1:0]  status_q;
  logic [ST_W-1:0]  status_d;
  logic [ST_W-1:0]  clr;
  logic [ST_W-1:0]  set;
  logic [THR_W-1:0] rdata_q;
  logic             irq_n_q;
  logic             wr_stat;

  assign wr_stat = reg_wr && (erx_addr_e'(reg_addr) == ADDR_STAT);

  always_comb begin
    set            = '0;
    set[ST_EARLY]  = set_early;
    set[ST_EOF]    = set_eof;
    clr            = wr_stat ? reg_wdata[ST_W-1:0] : '0;
    status_d       = (status_q & ~clr) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      status_q <= '0;
      rdata_q  <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      if (reg_wr && erx_addr_e'(reg_addr) == ADDR_THR) thr_q <= reg_wdata;
      status_q <= status_d;
      irq_n_q  <= ~|status_d;
      rdata_q  <= (erx_addr_e'(reg_addr) == ADDR_THR) ? thr_q
                                                     : THR_W'(status_q);
    end
  end

  assign thr       = thr_q;
  assign reg_rdata = rdata_q;
  assign irq_n     = irq_n_q;

  // R1: a write to the threshold address lands in the register
  a_r1_thr_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 1'b0) |=> thr_q == $past(reg_wdata));
  // R6: every frame end is recorded
  a_r6_eof_sticky: assert property (@(posedge clk) disable iff (rst)
    set_eof |=> status_q[ST_EOF]);
  // R8: writing one clears the early bit when no new event arrives
  a_r8_w1c_early: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[ST_EARLY] && !set_early) |=> !status_q[ST_EARLY]);
  // R9: the interrupt is released only once all status is clear
  a_r9_irq_release: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> (status_q == '0));
endmodule

// File: rtl/erx_early_irq.sv
`timescale 1ns/1ps
module erx_early_irq #(
  parameter int unsigned TL_OFFSET = 12,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned QW_BYTES  = 8,
  parameter int unsigned THR_W     = 8,
  parameter logic [15:0] ETYPE_MIN = 16'h0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [THR_W-1:0] reg_wdata,
  output logic [THR_W-1:0] reg_rdata,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  output logic             irq_n
);
  logic             frame_start;
  logic             frame_end;
  logic             tl_load;
  logic [LEN_W-1:0] tl_value;
  logic             pay_byte;
  logic             hit;
  logic [THR_W-1:0] thr;

  erx_frame_parser #(.TL_OFFSET(TL_OFFSET), .LEN_W(LEN_W)) u_parse (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .frame_start(frame_start),
    .frame_end(frame_end), .tl_load(tl_load), .tl_value(tl_value),
    .pay_byte(pay_byte));

  erx_qw_tracker #(.LEN_W(LEN_W), .QW_BYTES(QW_BYTES), .THR_W(THR_W),
                   .ETYPE_MIN(ETYPE_MIN)) u_track (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .tl_load(tl_load), .tl_value(tl_value), .pay_byte(pay_byte),
    .thr(thr), .hit(hit));

  erx_csr #(.THR_W(THR_W)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .set_early(hit), .set_eof(frame_end),
    .thr(thr), .reg_rdata(reg_rdata), .irq_n(irq_n));
endmodule

// File: tb/erx_early_irq_test.sv
`timescale 1ns/1ps
module erx_early_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic       rx_sof = 1'b0;
  logic       rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic       irq_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  erx_early_irq uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .irq_n(irq_n));

  typedef struct packed {
    logic [15:0] tl;
    logic [15:0] pay;
    logic [7:0]  thr;
    logic [15:0] fire;   // frame byte index that triggers, FFFF = none
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd40,    16'd40,  8'd2,   16'd37},
    '{16'd40,    16'd40,  8'd5,   16'd13},
    '{16'd37,    16'd37,  8'd1,   16'd45},
    '{16'd40,    16'd40,  8'd0,   16'hFFFF},
    '{16'h0800,  16'd40,  8'd2,   16'hFFFF},
    '{16'd16,    16'd16,  8'd3,   16'hFFFF},
    '{16'd100,   16'd100, 8'd13,  16'd13},
    '{16'd100,   16'd100, 8'd12,  16'd21},
    '{16'd1,     16'd10,  8'd1,   16'd13},
    '{16'h05FF,  16'd20,  8'd192, 16'd13},
    '{16'h0600,  16'd20,  8'd192, 16'hFFFF}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // stream one frame; first_low is the negedge index where irq_n is first low
  task automatic run_frame(input logic [15:0] tl, input int paylen,
                           input int mid, input logic [7:0] mid_thr,
                           output int first_low);
    int len;
    len = 14 + paylen;
    first_low = -1;
    for (int i = 0; i < len + 3; i++) begin
      @(negedge clk);
      if (first_low < 0 && !irq_n) first_low = i;
      reg_wr = 1'b0;
      if (i < len) begin
        rx_valid = 1'b1;
        rx_sof   = (i == 0);
        rx_eof   = (i == len - 1);
        rx_data  = (i == 12) ? tl[15:8] : (i == 13) ? tl[7:0] : 8'(i);
      end else begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      end
      if (mid >= 0 && i == mid) begin
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
      end
      if (mid >= 0 && i == mid + 1) begin
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = mid_thr;
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    int fl;
    int exp_low;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    reg_read(1'b0, d); check("R1 reset threshold", d, 0);
    reg_read(1'b1, d); check("R8 reset status", d, 0);
    check("R9 reset irq_n", irq_n, 1);

    // threshold read/write
    reg_write(1'b0, 8'hA5);
    reg_read(1'b0, d); check("R1 threshold readback", d, 8'hA5);

    // vector table
    for (int v = 0; v < NV; v++) begin
      reg_write(1'b0, VECS[v].thr);
      run_frame(VECS[v].tl, int'(VECS[v].pay), -1, 8'h00, fl);
      if (VECS[v].thr == 0)             tag = "R2 zero threshold";
      else if (VECS[v].tl >= 16'h0600)  tag = "R4 ethertype";
      else if (VECS[v].fire == 16'hFFFF) tag = "R5 short length";
      else                              tag = "R3 R10 early fire point";
      exp_low = (VECS[v].fire == 16'hFFFF) ? 14 + int'(VECS[v].pay)
                                           : int'(VECS[v].fire) + 2;
      check($sformatf("%s vec %0d", tag, v), fl, exp_low);
      reg_read(1'b1, d);
      check($sformatf("R6 status after vec %0d", v), d,
            (VECS[v].fire == 16'hFFFF) ? 2 : 3);
      reg_write(1'b1, 8'h03);
    end

    // once per frame: fire at byte 29, clear, lower threshold to 1
    reg_write(1'b0, 8'd3);
    run_frame(16'd40, 40, 31, 8'd1, fl);
    check("R7 first fire", fl, 31);
    reg_read(1'b1, d); check("R7 no second fire", d, 2);
    reg_write(1'b1, 8'h03);

    // re-armed by next start-of-frame with threshold 1
    run_frame(16'd40, 40, -1, 8'h00, fl);
    check("R7 rearm next frame", fl, 47);

    // write-one-to-clear per bit and interrupt level
    reg_read(1'b1, d); check("R8 both bits set", d, 3);
    check("R9 irq low with status", irq_n, 0);
    reg_write(1'b1, 8'h02);
    reg_read(1'b1, d); check("R8 clear eof only", d, 1);
    check("R9 irq still low", irq_n, 0);
    reg_write(1'b1, 8'h00);
    reg_read(1'b1, d); check("R8 zero write no effect", d, 1);
    reg_write(1'b1, 8'h01);
    reg_read(1'b1, d); check("R8 clear early", d, 0);
    check("R9 irq released", irq_n, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule